// File: doc/BRIEF.md
# Idle Interval Timer with Selectable Window

This block measures idle periods for a processor core. A down-counter runs all the time. It advances on every clock edge where the instruction-rate enable is high, whether or not the core is idle. Software cannot read, load, start or stop the counter.

A 3-bit window select register chooses one counter bit as the watched tap. Each time that tap underflows (goes from 0 to 1), the block does three things:

- it sets a sticky pending flag;
- it raises an interrupt request if interrupts are enabled;
- it ends the idle state.

Software enters idle by pulsing a request input. The idle-active output gates core execution. Idle also ends on reset or on a wake-up input. The counter phase is arbitrary when software enters idle, so idle lasts anywhere from one tick up to the selected window.

Changing the window select compares the newly chosen tap with the last sampled value of the old tap. That comparison can raise a pending event with no real underflow. The block models this on purpose.

Top module: `idle_window_timer`

## Requirements
- R1: While reset is asserted and after it is released, pend, irq and idle_active are 0, the window select is 0 and the counter holds CNT_INIT (default 0). From that value the first enabled tick wraps the counter to all ones, and pend rises one edge later.
- R2: The counter decrements by one, modulo 2^16, on each edge where tick_en is 1. It holds its value while tick_en is 0. With the counter held and the select unchanged, no pending event occurs.
- R3: Select value s in 0..4 watches counter bit 11+s. A pending event is a 0-to-1 change of that bit. Consecutive events are therefore 4096, 8192, 16384, 32768 or 65536 ticks apart. pend rises on the edge after the tick that changed the bit.
- R4: Select values 5, 6 and 7 behave exactly like 4 (bit 15, 65536-tick window).
- R5: sel_we loads sel_wdata into the select register on the clock edge. Reset returns the select to 0.
- R6: pend is sticky and is cleared only by pend_clr. An event and a clear on the same edge leave pend set.
- R7: irq equals pend AND irq_en, combinationally.
- R8: Idle state:
  - idle_req sets idle_active on the next edge;
  - a pending event or wake clears it on that edge;
  - when idle_req coincides with an event or wake, the exit wins.
- R9: On a select write, the tap last sampled under the old select is compared with the new tap. If the old value was 0 and the new tap is 1, pend is set on the following edge even with tick_en low. If the new tap is 0, no event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Instruction-rate count enable |
| sel_we | input | 1 | Window select write strobe |
| sel_wdata | input | 3 | Window select write data |
| pend_clr | input | 1 | Pending flag clear pulse |
| irq_en | input | 1 | Interrupt enable |
| idle_req | input | 1 | Enter-idle write pulse |
| wake | input | 1 | External wake-up |
| pend | output | 1 | Sticky pending flag |
| irq | output | 1 | Interrupt request |
| idle_active | output | 1 | Idle state, gates core execution |

## Verification
The timer is driven with an enable that ticks every cycle, with a sparse enable pattern and with the enable held low. These separate correct per-tick counting from counting on clock edges and from drift while frozen.

Full window intervals are measured for select 0, 1 and 7. These tell the right tap bit apart from its neighbours and confirm that out-of-range selects clamp.

Stimulus timed to coincide with an event distinguishes the priority orders for set-versus-clear and exit-versus-entry. Select writes made with the counter frozen isolate the spurious-event path from real underflows.

// File: rtl/iwt_pkg.sv
package iwt_pkg;
   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_IDLE = 1'b1
   } iwt_state_e;
endpackage

// File: rtl/iwt_counter.sv
module iwt_counter #(
   parameter int unsigned       CNT_W    = 16,
   parameter logic [CNT_W-1:0]  CNT_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= CNT_INIT;
      else if (tick_en) cnt <= cnt - CNT_W'(1);
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> cnt == $past(cnt) - CNT_W'(1));
   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt));
endmodule

// File: rtl/iwt_tap_detect.sv
module iwt_tap_detect #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned TAP_BASE = 11,
   parameter int unsigned NUM_WIN  = 5,
   parameter logic        TAP_RST  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] sel,
   output logic             tap_event
);
   localparam int unsigned SEL_CODES = 1 << SEL_W;
   localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_WIN - 1);

   logic [NUM_WIN-1:0] taps;
   logic [SEL_W-1:0]   sel_c;
   logic               tap_now;
   logic               tap_q;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_tap
      assign taps[w] = cnt[TAP_BASE + w];
   end

   if (NUM_WIN < SEL_CODES) begin : g_clamp
      assign sel_c = (sel > SEL_TOP) ? SEL_TOP : sel;
   end else begin : g_direct
      assign sel_c = sel;
   end

   assign tap_now = taps[sel_c];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q <= TAP_RST;
      else        tap_q <= tap_now;
   end

   assign tap_event = tap_now & ~tap_q;

   // R3
   event_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_event |=> tap_q);
endmodule

// File: rtl/iwt_idle_ctl.sv
module iwt_idle_ctl
   import iwt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic idle_req,
   input  logic wake,
   input  logic tap_event,
   output logic idle_active
);
   iwt_state_e st, st_nxt;

   always_comb begin
      st_nxt = st;
      if (idle_req)          st_nxt = ST_IDLE;
      if (tap_event || wake) st_nxt = ST_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RUN;
      else        st <= st_nxt;
   end

   assign idle_active = (st == ST_IDLE);

   // R8
   idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_event || wake) |=> !idle_active);
   // R8
   idle_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_req && !tap_event && !wake) |=> idle_active);
   // R8
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_active && !tap_event && !wake) |=> idle_active);
endmodule

// File: rtl/idle_window_timer.sv
module idle_window_timer
   import iwt_pkg::*;
#(
   parameter int unsigned       CNT_W    = 16,
   parameter int unsigned       SEL_W    = 3,
   parameter int unsigned       TAP_BASE = 11,
   parameter int unsigned       NUM_WIN  = 5,
   parameter logic [CNT_W-1:0]  CNT_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             sel_we,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             pend_clr,
   input  logic             irq_en,
   input  logic             idle_req,
   input  logic             wake,
   output logic             pend,
   output logic             irq,
   output logic             idle_active
);
   localparam int unsigned TAP_TOP = TAP_BASE + NUM_WIN - 1;
   localparam logic        TAP_RST = CNT_INIT[TAP_BASE];

   if (TAP_TOP >= CNT_W) begin : g_bad_tap
      $error("window taps exceed counter width");
   end
   if (NUM_WIN == 0 || NUM_WIN > (1 << SEL_W)) begin : g_bad_win
      $error("window count does not fit the select field");
   end

   logic [CNT_W-1:0] cnt;
   logic [SEL_W-1:0] sel_q;
   logic             tap_event;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_we) sel_q <= sel_wdata;
   end

   iwt_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cnt     (cnt)
   );

   iwt_tap_detect #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .TAP_BASE(TAP_BASE),
      .NUM_WIN(NUM_WIN), .TAP_RST(TAP_RST)
   ) u_tap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .sel       (sel_q),
      .tap_event (tap_event)
   );

   iwt_idle_ctl u_idle (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle_req    (idle_req),
      .wake        (wake),
      .tap_event   (tap_event),
      .idle_active (idle_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= 1'b0;
      else if (tap_event) pend <= 1'b1;
      else if (pend_clr)  pend <= 1'b0;
   end

   assign irq = pend & irq_en;

   // R6
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_event |=> pend);
   // R6
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !pend_clr) |=> pend);
   // R6
   pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !tap_event) |=> !pend);
endmodule

// File: tb/idle_window_timer_tb.sv
module idle_window_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0, sel_we = 1'b0, pend_clr = 1'b0;
   logic       irq_en = 1'b0, idle_req = 1'b0, wake = 1'b0;
   logic [2:0] sel_wdata = '0;
   logic       pend, irq, idle_active;

   always #4 clk = ~clk;

   idle_window_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel_we(sel_we),
      .sel_wdata(sel_wdata), .pend_clr(pend_clr), .irq_en(irq_en),
      .idle_req(idle_req), .wake(wake), .pend(pend), .irq(irq),
      .idle_active(idle_active)
   );

   typedef struct {
      int unsigned cyc;
      logic        pend;
      logic        idle;
   } exp_t;

   exp_t        sb_q[$];
   int unsigned cyc = 0;
   int          checks = 0;
   int          fails = 0;
   string       cur_req = "R1";

   logic [15:0] m_cnt;
   logic        m_tapq, m_pend, m_idle;
   logic [2:0]  m_sel;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int m_idx();
      return 11 + ((m_sel > 3'd4) ? 4 : int'(m_sel));
   endfunction

   function automatic logic m_ev();
      return m_cnt[m_idx()] & ~m_tapq;
   endfunction

   task automatic m_reset();
      m_cnt = '0; m_tapq = 1'b0; m_pend = 1'b0; m_idle = 1'b0; m_sel = '0;
   endtask

   // driver: applies inputs for the next edge, predicts, pushes expectation
   task automatic step(input logic tk, input logic we, input logic [2:0] wd,
                       input logic clr, input logic ireq, input logic wk);
      logic ev, tq;
      exp_t e;
      tick_en = tk; sel_we = we; sel_wdata = wd;
      pend_clr = clr; idle_req = ireq; wake = wk;
      ev = m_ev();
      tq = m_cnt[m_idx()];
      if (tk) m_cnt = m_cnt - 16'd1;
      m_tapq = tq;
      m_pend = ev | (m_pend & ~clr);
      m_idle = (m_idle | ireq) & ~(ev | wk);
      if (we) m_sel = wd;
      e.cyc = cyc + 1; e.pend = m_pend; e.idle = m_idle;
      sb_q.push_back(e);
      @(posedge clk);
      #1;
      tick_en = 1'b0; sel_we = 1'b0; pend_clr = 1'b0; idle_req = 1'b0; wake = 1'b0;
   endtask

   task automatic ticks_to_pend(output int n);
      n = 0;
      do begin
         step(1'b1, 1'b0, 3'd0, (n == 0), 1'b0, 1'b0);
         n++;
      end while (pend !== 1'b1 && n < 70000);
   endtask

   // monitor: compares design outputs against the queued expectations
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
            e = sb_q.pop_front();
            chk(cur_req, "scoreboard pend", pend, e.pend);
            chk(cur_req, "scoreboard idle_active", idle_active, e.idle);
            chk("R7", "scoreboard irq", irq, e.pend & irq_en);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      int s_n;
      m_reset();
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "pend in reset", pend, 0);
      chk("R1", "irq in reset", irq, 0);
      chk("R1", "idle in reset", idle_active, 0);
      rst_n = 1'b1;

      // longest window via clamped select 7 from a fresh counter
      cur_req = "R4";
      step(1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
      ticks_to_pend(n);
      chk("R1", "first event after reset (ticks)", n, 2);
      ticks_to_pend(n);
      chk("R4", "select 7 window (ticks)", n, 65536);

      // back to shortest window, sticky flag and set/clear collision
      cur_req = "R6";
      step(1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
      while (m_ev()) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
      chk("R6", "pend after clear", pend, 0);
      while (!m_ev()) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
      chk("R6", "set wins over same-edge clear", pend, 1);
      for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R6", "pend sticky without clear", pend, 1);

      // interrupt gating
      irq_en = 1'b1;
      #3;
      chk("R7", "irq with pend and enable", irq, 1);
      irq_en = 1'b0;
      #1;
      chk("R7", "irq with enable low", irq, 0);
      irq_en = 1'b1;
      step(1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
      chk("R7", "irq with pend low", irq, 0);

      // idle entry, exit on event, wake, exit priority
      cur_req = "R8";
      step(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      chk("R8", "idle entered", idle_active, 1);
      while (!m_ev()) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R8", "idle held until event", idle_active, 1);
      step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R8", "idle ends on event", idle_active, 0);
      chk("R8", "event sets pend during idle", pend, 1);
      step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R8", "idle before wake", idle_active, 1);
      step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1);
      chk("R8", "wake ends idle", idle_active, 0);
      while (!m_ev()) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0);
      chk("R8", "exit wins over same-edge entry", idle_active, 0);
      irq_en = 1'b0;

      // spurious event on select change with counter frozen
      cur_req = "R9";
      while (!(m_cnt[11] == 1'b0 && m_tapq == 1'b0 && m_cnt[15:12] != 4'd0))
         step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      s_n = 1;
      while (!m_cnt[11 + s_n]) s_n++;
      step(1'b0, 1'b1, 3'(s_n), 1'b1, 1'b0, 1'b0);
      chk("R9", "pend clear at select write", pend, 0);
      step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R9", "spurious event from new high tap", pend, 1);
      step(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R9", "no event when new tap is low", pend, 0);

      // frozen counter then sparse enable pattern
      cur_req = "R2";
      for (int i = 0; i < 5000; i++) step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
      chk("R2", "no event while tick_en low", pend, 0);
      for (int i = 0; i < 3000; i++) step((i % 3) != 0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);

      // second-shortest window
      cur_req = "R3";
      step(1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0);
      ticks_to_pend(n);
      ticks_to_pend(n);
      chk("R3", "select 1 window (ticks)", n, 8192);

      // reset restores select 0
      #2;
      rst_n = 1'b0;
      #10;
      chk("R5", "pend in second reset", pend, 0);
      chk("R5", "idle in second reset", idle_active, 0);
      m_reset();
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      cur_req = "R5";
      ticks_to_pend(n);
      chk("R1", "first event after second reset (ticks)", n, 2);
      ticks_to_pend(n);
      chk("R5", "default select 0 window after reset (ticks)", n, 4096);

      #3;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule